// File: doc/BRIEF.md
# Nine-Bit ROM Bank Controller

This block maps a 16-bit CPU address space onto a large external ROM and a banked external RAM. CPU writes into the low half of the address space never reach memory. Instead, they load a small set of control registers: a RAM access key, an 8-bit low ROM bank, a single high ROM bank bit, and a 4-bit RAM bank. The two ROM bank registers together form a 9-bit bank number that drives the upper half of a 16 KiB switchable window. A second 16 KiB window is fixed on bank 0.

The block drives the physical ROM and RAM addresses combinationally from the CPU address. It also gates the RAM strobes and multiplexes the read byte back to the CPU. RAM reads return 0xFF when the RAM is not unlocked or when the address lies beyond the installed RAM. Two configuration inputs set the ROM size and the RAM size: the ROM bank count as a power of two, and the installed RAM as a count of 256-byte pages. The ROM and RAM arrays sit outside the block.

Top module: `rombank9_ctrl`

## Requirements
- R1: A write with cpu_addr in 0x0000-0x1FFF unlocks RAM only when cpu_wdata equals exactly 0x0A. Any other byte, including 0x1A and 0x8A, locks it.
- R2: A write with cpu_addr in 0x2000-0x2FFF loads all 8 bits of cpu_wdata into the low ROM bank register. Bank bits 7:0 take the new value from the next cycle on.
- R3: A write with cpu_addr in 0x3000-0x3FFF loads only cpu_wdata bit 0, which becomes ROM bank bit 8. Data bits 7:1 have no effect.
- R4: The effective bank is the 9-bit value {high bit, low byte} modulo 2^N. N is cfg_rom_banks_log2 clamped to 9, and it must be at least 1. The result updates as soon as either register or N changes.
- R5: A write with cpu_addr in 0x4000-0x5FFF loads cpu_wdata bits 3:0 as the RAM bank. ram_addr = {RAM bank, cpu_addr[12:0]}, which gives 8 KiB per bank.
- R6: For cpu_addr in 0xA000-0xBFFF, access is granted only when RAM is unlocked and cpu_addr[12:8] < cfg_ram_pages. Values of 32 or more mean a full 8 KiB. When access is granted, ram_cs is 1, ram_we equals cpu_wr, and cpu_rdata equals ram_rdata. Otherwise ram_cs and ram_we are 0 and cpu_rdata is 0xFF.
- R7: For cpu_addr in 0x0000-0x3FFF, rom_addr = {9'b0, cpu_addr[13:0]}. For 0x4000-0x7FFF, rom_addr = {effective bank, cpu_addr[13:0]}. For the whole 0x0000-0x7FFF range, cpu_rdata equals rom_rdata.
- R8: After reset the RAM is locked, the low bank is 1, the high bit is 0 and the RAM bank is 0. The switchable window therefore shows bank 1.
- R9: When the 9-bit bank value is 0, the switchable window maps to bank 0. No bank is substituted.
- R10: Writes to 0x6000-0x7FFF change no state. Reads at 0x8000-0x9FFF and 0xC000-0xFFFF return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one write per cycle it is high |
| cfg_rom_banks_log2 | input | 4 | log2 of the ROM bank count (1..9, larger clamps to 9) |
| cfg_ram_pages | input | 6 | Installed RAM per window in 256-byte pages (32 or more = 8 KiB) |
| rom_rdata | input | 8 | Byte returned by the ROM array |
| ram_rdata | input | 8 | Byte returned by the RAM array |
| rom_addr | output | 23 | Physical ROM byte address |
| ram_addr | output | 17 | Physical RAM byte address |
| ram_cs | output | 1 | RAM access granted |
| ram_we | output | 1 | RAM write enable |
| cpu_rdata | output | 8 | Read byte returned to the CPU |

## Verification
The assertions watch the following on every cycle:
- the register loads caused by each write window, including the exact-byte unlock;
- the bank staying below the configured bank count;
- the fixed window never carrying bank bits;
- the 0xFF and no-strobe result of a locked RAM;
- the ignored 0x6000-0x7FFF writes.

Only the bench scenarios can show the following:
- the modulo wrap after a ROM-size change;
- the exact RAM page boundary under a reduced page count;
- bank 0 appearing in the switchable window;
- the full-address arithmetic for each window.

The bench shows these by comparing every output against a behavioural model on every cycle.

// File: rtl/rb9_pkg.sv
package rb9_pkg;

  localparam logic [7:0] RAM_KEY  = 8'h0A;
  localparam logic [7:0] OPEN_BUS = 8'hFF;

  typedef enum logic [2:0] {
    WT_NONE,
    WT_RAMEN,
    WT_BANKLO,
    WT_BANKHI,
    WT_RAMBANK,
    WT_IGNORED,
    WT_RAMDATA
  } wr_tgt_e;

  // Write target from the top address nibble
  function automatic wr_tgt_e decode_wr(input logic [3:0] nib);
    case (nib)
      4'h0, 4'h1: return WT_RAMEN;
      4'h2:       return WT_BANKLO;
      4'h3:       return WT_BANKHI;
      4'h4, 4'h5: return WT_RAMBANK;
      4'h6, 4'h7: return WT_IGNORED;
      4'hA, 4'hB: return WT_RAMDATA;
      default:    return WT_NONE;
    endcase
  endfunction

  function automatic logic in_rom_space(input logic [15:0] a);
    return !a[15];
  endfunction

  function automatic logic in_ram_window(input logic [15:0] a);
    return a[15:13] == 3'b101;
  endfunction

  // RAM key compare: the whole byte must match
  function automatic logic key_match(input logic [7:0] d);
    return d == RAM_KEY;
  endfunction

endpackage

// File: rtl/rb9_wr_decode.sv
module rb9_wr_decode
  import rb9_pkg::*;
(
  input  logic [3:0] addr_nib,
  input  logic       wr,
  output logic       stb_ramen,
  output logic       stb_lo,
  output logic       stb_hi,
  output logic       stb_rambank,
  output logic       stb_ignored
);
  wr_tgt_e tgt;

  always_comb begin
    tgt         = decode_wr(addr_nib);
    stb_ramen   = wr && (tgt == WT_RAMEN);
    stb_lo      = wr && (tgt == WT_BANKLO);
    stb_hi      = wr && (tgt == WT_BANKHI);
    stb_rambank = wr && (tgt == WT_RAMBANK);
    stb_ignored = wr && (tgt == WT_IGNORED);
  end
endmodule

// File: rtl/rb9_bank_regs.sv
module rb9_bank_regs
  import rb9_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  localparam int LO_W = 8,
  localparam int HI_W = ROM_BANK_W - LO_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            wdata,
  input  logic                  stb_ramen,
  input  logic                  stb_lo,
  input  logic                  stb_hi,
  input  logic                  stb_rambank,
  output logic                  ram_on,
  output logic [LO_W-1:0]       bank_lo,
  output logic [HI_W-1:0]       bank_hi,
  output logic [RAM_BANK_W-1:0] ram_bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_on   <= 1'b0;
      bank_lo  <= LO_W'(1);
      bank_hi  <= '0;
      ram_bank <= '0;
    end else begin
      if (stb_ramen)   ram_on   <= key_match(wdata);
      if (stb_lo)      bank_lo  <= wdata;
      if (stb_hi)      bank_hi  <= wdata[HI_W-1:0];
      if (stb_rambank) ram_bank <= wdata[RAM_BANK_W-1:0];
    end
  end
endmodule

// File: rtl/rb9_rom_map.sv
module rb9_rom_map #(
  parameter int ROM_BANK_W = 9,
  parameter int WIN_AW     = 14,
  parameter int LOG_W      = 4,
  localparam int ROM_AW    = ROM_BANK_W + WIN_AW
) (
  input  logic [ROM_BANK_W-1:0] bank_raw,
  input  logic [LOG_W-1:0]      cfg_log2,
  input  logic [WIN_AW:0]       addr,
  output logic [ROM_BANK_W-1:0] bank_eff,
  output logic [ROM_AW-1:0]     rom_addr
);
  logic [ROM_BANK_W-1:0] bank_mask;

  // Bit i survives when the bank count exceeds 2^i; counts above 2^ROM_BANK_W keep all bits
  for (genvar i = 0; i < ROM_BANK_W; i++) begin : g_mask
    assign bank_mask[i] = (cfg_log2 > LOG_W'(i));
  end

  function automatic logic [ROM_BANK_W-1:0] wrap_bank(input logic [ROM_BANK_W-1:0] raw,
                                                      input logic [ROM_BANK_W-1:0] mask);
    return raw & mask;
  endfunction

  always_comb begin
    bank_eff = wrap_bank(bank_raw, bank_mask);
    if (addr[WIN_AW]) rom_addr = {bank_eff, addr[WIN_AW-1:0]};
    else              rom_addr = {{ROM_BANK_W{1'b0}}, addr[WIN_AW-1:0]};
  end
endmodule

// File: rtl/rb9_ram_gate.sv
module rb9_ram_gate
  import rb9_pkg::*;
#(
  parameter int RAM_BANK_W = 4,
  parameter int RAM_AW     = 13,
  localparam int PG_W      = RAM_AW - 8 + 1,
  localparam int RAM_PAW   = RAM_BANK_W + RAM_AW
) (
  input  logic [15:0]           addr,
  input  logic                  wr,
  input  logic                  ram_on,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic [PG_W-1:0]       cfg_pages,
  input  logic [7:0]            rom_rdata,
  input  logic [7:0]            ram_rdata,
  output logic [RAM_PAW-1:0]    ram_addr,
  output logic                  page_ok,
  output logic                  ram_cs,
  output logic                  ram_we,
  output logic [7:0]            cpu_rdata
);
  // A page index can never reach 2^(PG_W-1), so large counts mean a full window
  function automatic logic page_present(input logic [PG_W-2:0] page,
                                        input logic [PG_W-1:0] pages);
    return {1'b0, page} < pages;
  endfunction

  always_comb begin
    ram_addr = {ram_bank, addr[RAM_AW-1:0]};
    page_ok  = page_present(addr[RAM_AW-1:8], cfg_pages);
    ram_cs   = in_ram_window(addr) && ram_on && page_ok;
    ram_we   = ram_cs && wr;
    if (in_rom_space(addr)) cpu_rdata = rom_rdata;
    else if (ram_cs)        cpu_rdata = ram_rdata;
    else                    cpu_rdata = OPEN_BUS;
  end
endmodule

// File: rtl/rombank9_ctrl.sv
module rombank9_ctrl #(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int WIN_AW     = 14,
  parameter int RAM_AW     = 13,
  localparam int LOG_W     = $clog2(ROM_BANK_W + 1),
  localparam int PG_W      = RAM_AW - 8 + 1,
  localparam int ROM_AW    = ROM_BANK_W + WIN_AW,
  localparam int RAM_PAW   = RAM_BANK_W + RAM_AW,
  localparam int HI_W      = ROM_BANK_W - 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic               cpu_wr,
  input  logic [LOG_W-1:0]   cfg_rom_banks_log2,
  input  logic [PG_W-1:0]    cfg_ram_pages,
  input  logic [7:0]         rom_rdata,
  input  logic [7:0]         ram_rdata,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic [RAM_PAW-1:0] ram_addr,
  output logic               ram_cs,
  output logic               ram_we,
  output logic [7:0]         cpu_rdata
);
  // Named internal events for the checker
  logic                  stb_ramen, stb_lo, stb_hi, stb_rambank, stb_ignored;
  logic                  ram_on;
  logic [7:0]            bank_lo;
  logic [HI_W-1:0]       bank_hi;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic [ROM_BANK_W-1:0] bank_eff;
  logic                  page_ok;

  rb9_wr_decode u_dec (
    .addr_nib    (cpu_addr[15:12]),
    .wr          (cpu_wr),
    .stb_ramen   (stb_ramen),
    .stb_lo      (stb_lo),
    .stb_hi      (stb_hi),
    .stb_rambank (stb_rambank),
    .stb_ignored (stb_ignored)
  );

  rb9_bank_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdata       (cpu_wdata),
    .stb_ramen   (stb_ramen),
    .stb_lo      (stb_lo),
    .stb_hi      (stb_hi),
    .stb_rambank (stb_rambank),
    .ram_on      (ram_on),
    .bank_lo     (bank_lo),
    .bank_hi     (bank_hi),
    .ram_bank    (ram_bank)
  );

  rb9_rom_map #(.ROM_BANK_W(ROM_BANK_W), .WIN_AW(WIN_AW), .LOG_W(LOG_W)) u_rom (
    .bank_raw (ROM_BANK_W'({bank_hi, bank_lo})),
    .cfg_log2 (cfg_rom_banks_log2),
    .addr     (cpu_addr[WIN_AW:0]),
    .bank_eff (bank_eff),
    .rom_addr (rom_addr)
  );

  rb9_ram_gate #(.RAM_BANK_W(RAM_BANK_W), .RAM_AW(RAM_AW)) u_ram (
    .addr      (cpu_addr),
    .wr        (cpu_wr),
    .ram_on    (ram_on),
    .ram_bank  (ram_bank),
    .cfg_pages (cfg_ram_pages),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .ram_addr  (ram_addr),
    .page_ok   (page_ok),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );
endmodule

// File: rtl/rombank9_ctrl_chk.sv
module rombank9_ctrl_chk #(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int WIN_AW     = 14,
  parameter int LOG_W      = 4,
  localparam int ROM_AW    = ROM_BANK_W + WIN_AW,
  localparam int HI_W      = ROM_BANK_W - 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_wdata,
  input logic                  cpu_wr,
  input logic [LOG_W-1:0]      cfg_rom_banks_log2,
  input logic [ROM_AW-1:0]     rom_addr,
  input logic                  ram_cs,
  input logic                  ram_we,
  input logic [7:0]            cpu_rdata,
  input logic                  ram_on,
  input logic [7:0]            bank_lo,
  input logic [HI_W-1:0]       bank_hi,
  input logic [RAM_BANK_W-1:0] ram_bank,
  input logic [ROM_BANK_W-1:0] bank_eff
);
  logic [LOG_W-1:0] lg_clamped;
  assign lg_clamped = (cfg_rom_banks_log2 > LOG_W'(ROM_BANK_W)) ? LOG_W'(ROM_BANK_W)
                                                                : cfg_rom_banks_log2;

  a_r1_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata == 8'h0A) |=> ram_on);

  a_r1_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata != 8'h0A) |=> !ram_on);

  a_r2_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h2) |=> bank_lo == $past(cpu_wdata));

  a_r3_high_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h3) |=> bank_hi == $past(cpu_wdata[HI_W-1:0]));

  a_r4_bank_below_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_eff >> lg_clamped) == '0);

  a_r5_ram_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b010) |=> ram_bank == $past(cpu_wdata[RAM_BANK_W-1:0]));

  a_r6_locked_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b101 && !ram_on) |-> (cpu_rdata == 8'hFF && !ram_we && !ram_cs));

  a_r6_we_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && ram_cs));

  a_r7_fixed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> rom_addr[ROM_AW-1:WIN_AW] == '0);

  a_r10_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=>
      ($stable(ram_on) && $stable(bank_lo) && $stable(bank_hi) && $stable(ram_bank)));
endmodule

bind rombank9_ctrl rombank9_ctrl_chk #(
  .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W), .WIN_AW(WIN_AW), .LOG_W(LOG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
  .cfg_rom_banks_log2(cfg_rom_banks_log2), .rom_addr(rom_addr), .ram_cs(ram_cs),
  .ram_we(ram_we), .cpu_rdata(cpu_rdata), .ram_on(ram_on), .bank_lo(bank_lo),
  .bank_hi(bank_hi), .ram_bank(ram_bank), .bank_eff(bank_eff)
);

// File: tb/rombank9_ctrl_tb.sv
`timescale 1ns/1ps
module rombank9_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [3:0]  cfg_rom_banks_log2 = 4'd9;
  logic [5:0]  cfg_ram_pages = 6'd32;
  logic [7:0]  rom_rdata = '0;
  logic [7:0]  ram_rdata = '0;
  logic [22:0] rom_addr;
  logic [16:0] ram_addr;
  logic        ram_cs, ram_we;
  logic [7:0]  cpu_rdata;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  // Reference model state
  int m_on = 0, m_lo = 1, m_hi = 0, m_rb = 0;

  always #10 clk = ~clk;

  rombank9_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .cfg_rom_banks_log2(cfg_rom_banks_log2), .cfg_ram_pages(cfg_ram_pages),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .ram_cs(ram_cs), .ram_we(ram_we), .cpu_rdata(cpu_rdata)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (addr=%04h)", tag, what, act, exp, cpu_addr);
    end
  endtask

  // One bus cycle: drive, compare all outputs against the model, then advance the model
  task automatic step(input int a, input int d, input bit w, input string tag);
    int n, bank, off, lim;
    bit in_ram, grant;
    @(negedge clk);
    cyc++;
    cpu_addr  = 16'(a);
    cpu_wdata = 8'(d);
    cpu_wr    = w;
    rom_rdata = 8'((cyc * 37 + 5) % 255);
    ram_rdata = 8'((cyc * 53 + 11) % 255);
    #4;
    n = (int'(cfg_rom_banks_log2) > 9) ? 9 : int'(cfg_rom_banks_log2);
    bank = (m_hi * 256 + m_lo) % (2 ** n);
    if (a < 'h8000)
      check(tag, "rom_addr", int'(rom_addr),
            (a < 'h4000) ? a : bank * 16384 + (a % 16384));
    in_ram = (a >= 'hA000) && (a < 'hC000);
    off    = a - 'hA000;
    lim    = ((int'(cfg_ram_pages) > 32) ? 32 : int'(cfg_ram_pages)) * 256;
    grant  = in_ram && (m_on != 0) && (off < lim);
    if (in_ram) check(tag, "ram_addr", int'(ram_addr), m_rb * 8192 + off);
    check(tag, "ram_cs", int'(ram_cs), int'(grant));
    check(tag, "ram_we", int'(ram_we), int'(grant && w));
    check(tag, "cpu_rdata", int'(cpu_rdata),
          (a < 'h8000) ? int'(rom_rdata) : (grant ? int'(ram_rdata) : 'hFF));
    if (w) begin
      if (a < 'h2000)      m_on = (d == 'h0A) ? 1 : 0;
      else if (a < 'h3000) m_lo = d;
      else if (a < 'h4000) m_hi = d % 2;
      else if (a < 'h6000) m_rb = d % 16;
    end
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state: bank 1 in the switchable window, RAM locked
    step('h4000, 0, 0, "R8");
    step('h7FFF, 0, 0, "R8");
    step('hA000, 0, 0, "R8");
    // R1 exact key unlock and lock
    step('h0000, 'h0A, 1, "R1");
    step('hA123, 0, 0, "R1");
    step('hB000, 'h55, 1, "R1");
    step('h1FFF, 'h1A, 1, "R1");
    step('hA123, 0, 0, "R1");
    step('h0100, 'h0A, 1, "R1");
    step('h0100, 'h8A, 1, "R1");
    step('hA000, 'h33, 1, "R1");
    step('h1000, 'h0A, 1, "R1");
    // R2 full low byte, R3 single high bit
    step('h2000, 'hFF, 1, "R2");
    step('h7FFF, 0, 0, "R2");
    step('h2FFF, 'hA5, 1, "R2");
    step('h5ABC, 0, 0, "R2");
    step('h3000, 'hFF, 1, "R3");
    step('h4001, 0, 0, "R3");
    step('h3FFF, 'hFE, 1, "R3");
    step('h4001, 0, 0, "R3");
    step('h3800, 'h01, 1, "R3");
    step('h2000, 'hFF, 1, "R3");
    step('h7000, 0, 0, "R3");
    // R4 wrap by bank count, including the clamp
    cfg_rom_banks_log2 = 4'd4;
    step('h4000, 0, 0, "R4");
    cfg_rom_banks_log2 = 4'd1;
    step('h6000 - 1, 0, 0, "R4");
    cfg_rom_banks_log2 = 4'd8;
    step('h4002, 0, 0, "R4");
    cfg_rom_banks_log2 = 4'd15;
    step('h4002, 0, 0, "R4");
    step('h2000, 'h13, 1, "R4");
    cfg_rom_banks_log2 = 4'd5;
    step('h4444, 0, 0, "R4");
    cfg_rom_banks_log2 = 4'd9;
    // R9 bank 0 selectable in the switchable window
    step('h3000, 'h00, 1, "R9");
    step('h2000, 'h00, 1, "R9");
    step('h4000, 0, 0, "R9");
    step('h7FFF, 0, 0, "R9");
    // R7 fixed window ignores the bank
    step('h2000, 'h7E, 1, "R7");
    step('h3000, 'h01, 1, "R7");
    step('h0123, 0, 0, "R7");
    step('h3FFF, 0, 0, "R7");
    step('h4000, 0, 0, "R7");
    // R5 RAM bank low nibble
    step('h4000, 'hF7, 1, "R5");
    step('hA000, 'h11, 1, "R5");
    step('hBFFF, 0, 0, "R5");
    step('h5FFF, 'h1C, 1, "R5");
    step('hA800, 0, 0, "R5");
    // R6 page limit
    cfg_ram_pages = 6'd16;
    step('hAFFF, 'h22, 1, "R6");
    step('hB000, 'h22, 1, "R6");
    step('hB100, 0, 0, "R6");
    cfg_ram_pages = 6'd0;
    step('hA000, 'h44, 1, "R6");
    cfg_ram_pages = 6'd1;
    step('hA0FF, 0, 0, "R6");
    step('hA100, 0, 0, "R6");
    cfg_ram_pages = 6'd40;
    step('hBFFF, 'h66, 1, "R6");
    step('h1000, 'h00, 1, "R6");
    step('hBFFF, 'h66, 1, "R6");
    step('h1000, 'h0A, 1, "R6");
    // R10 ignored writes and open regions
    step('h6000, 'hFF, 1, "R10");
    step('h7FFF, 'h00, 1, "R10");
    step('h4321, 0, 0, "R10");
    step('hA000, 0, 0, "R10");
    step('h8000, 'h12, 1, "R10");
    step('h9FFF, 0, 0, "R10");
    step('hC000, 'h34, 1, "R10");
    step('hFFFF, 0, 0, "R10");
    step('h4321, 0, 0, "R10");
    // Mixed sweep of the switchable window
    for (int k = 0; k < 40; k++) begin
      step('h2000, (k * 29) % 256, 1, "R2");
      step('h3000, k, 1, "R3");
      cfg_rom_banks_log2 = 4'(1 + (k % 10));
      step('h4000 + k * 97, 0, 0, "R4");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule